// File: doc/BRIEF.md
# Sliding-Window Cumulative Histogram Engine

The engine tracks the distribution of a streaming sample input over a sliding window of the most recent samples. It accepts one sample on every clock and reduces it to a bin index taken from its upper bits. A thermometer pattern table converts that index into a mask with a one on every bin at or above the index. A second read of the same table is made for the index that is leaving the window. Each bin counter then increments, decrements or holds. This means every bin holds the number of windowed samples whose index is less than or equal to its own. The result is a cumulative histogram, and it is exposed in parallel on every cycle.

The window length is always a power of two and is chosen at run time. The index that leaves the window is taken from a fixed tap on a delay line of stored indices. No division is performed. A consumer reads a count as a fixed-point fraction with `frac_bits` fractional bits, and this yields the cumulative probability directly. Probability lookups and centile searches are meant to sit downstream and read `bin_counts`.

Top module: `cumhist_engine`

## Requirements
- R1: The bin index of a sample is its top BIN_BITS bits (default: bits 11..8 of a 12-bit sample); the lower bits have no effect on any count.
- R2: After each clock edge, bin b (bits [b*CNT_W +: CNT_W] of `bin_counts`) equals the number of samples in the current window whose index is less than or equal to b.
- R3: The window length is 2^(2+win_sel) for win_sel 0..3 and 64 for any win_sel of 4 or more. Once the window is full, the sample leaving the window is removed in the same cycle the new one is added.
- R4: No sample is removed until the window has filled. `win_full` is 1 exactly when the window holds its full length of samples.
- R5: When the entering and leaving samples share an index, every count holds its value.
- R6: A change of the effective window length clears all counts and the fill state on that edge. The sample presented on that edge is not counted.
- R7: Each count is MAX_LOG+1 bits wide (7 by default), so a full 64-sample window of index 0 reads 64 in every bin with no wrap.
- R8: `frac_bits` gives log2 of the current window length, the position of the binary point for normalisation.
- R9: A synchronous active-high reset clears all counts, clears `win_full` and loads the window length from `win_sel`; samples presented during reset are not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_data | input | SAMPLE_W | Sample taken on every clock |
| win_sel | input | SEL_W | Window length select |
| bin_counts | output | NBINS*CNT_W | All cumulative counts, bin b in slice b |
| win_full | output | 1 | Window holds its full length |
| frac_bits | output | LOG_W | Binary point position (log2 of window) |

## Verification
All outputs are registered. A sample or window select presented before a rising edge is reflected in `bin_counts`, `win_full` and `frac_bits` immediately after that edge, with zero extra latency. The bench drives inputs on the falling edge and advances a queue-based model at the same moment. It then compares every output against that model on the next falling edge, once per clock. Targeted checks after chosen steps confirm the fill boundary, same-index replacement, window changes and saturation of a full window.

// File: rtl/cumhist_pkg.sv
package cumhist_pkg;

    typedef enum logic [1:0] {
        CMD_HOLD = 2'd0,
        CMD_INC  = 2'd1,
        CMD_DEC  = 2'd2
    } bin_cmd_t;

    // Resolve the two mask bits of one bin into a counter command.
    function automatic bin_cmd_t resolve_cmd(input logic inc, input logic dec);
        bin_cmd_t c;
        if (inc && !dec)      c = CMD_INC;
        else if (dec && !inc) c = CMD_DEC;
        else                  c = CMD_HOLD;
        return c;
    endfunction

endpackage

// File: rtl/cumhist_delay.sv
module cumhist_delay #(
    parameter int IDX_W   = 4,
    parameter int MIN_LOG = 2,
    parameter int MAX_LOG = 6,
    parameter int LOG_W   = 3
) (
    input  logic             clk,
    input  logic [IDX_W-1:0] in_idx,
    input  logic [LOG_W-1:0] win_log,
    output logic [IDX_W-1:0] out_idx
);
    localparam int DEPTH    = 1 << MAX_LOG;
    localparam int NUM_TAPS = MAX_LOG - MIN_LOG + 1;

    logic [IDX_W-1:0] line_q [DEPTH];
    logic [IDX_W-1:0] taps   [NUM_TAPS];

    always_ff @(posedge clk) begin
        line_q[0] <= in_idx;
        for (int i = 1; i < DEPTH; i++) line_q[i] <= line_q[i-1];
    end

    // Stage (2^k)-1 holds the index that entered 2^k edges ago.
    for (genvar k = 0; k < NUM_TAPS; k++) begin : g_tap
        assign taps[k] = line_q[(1 << (MIN_LOG + k)) - 1];
    end

    always_comb begin
        out_idx = taps[0];
        for (int k = 0; k < NUM_TAPS; k++)
            if (int'(win_log) == MIN_LOG + k) out_idx = taps[k];
    end
endmodule

// File: rtl/cumhist_pattern.sv
module cumhist_pattern #(
    parameter int IDX_W = 4
) (
    input  logic [IDX_W-1:0]        add_idx,
    input  logic [IDX_W-1:0]        drop_idx,
    input  logic                    drop_en,
    output logic [(1<<IDX_W)-1:0]   inc_mask,
    output logic [(1<<IDX_W)-1:0]   dec_mask
);
    localparam int NBINS = 1 << IDX_W;

    // Thermometer table: word a has a one on every bin b >= a.
    logic [NBINS-1:0] table_w [NBINS];

    for (genvar a = 0; a < NBINS; a++) begin : g_word
        for (genvar b = 0; b < NBINS; b++) begin : g_bit
            assign table_w[a][b] = (b >= a);
        end
    end

    assign inc_mask = table_w[add_idx];
    assign dec_mask = drop_en ? table_w[drop_idx] : '0;
endmodule

// File: rtl/cumhist_bin.sv
module cumhist_bin
    import cumhist_pkg::*;
#(
    parameter int CNT_W   = 7,
    parameter int MAX_CNT = 64
) (
    input  logic             clk,
    input  logic             clr,
    input  logic             inc,
    input  logic             dec,
    output logic [CNT_W-1:0] count
);
    bin_cmd_t cmd;
    assign cmd = resolve_cmd(inc, dec);

    always_ff @(posedge clk) begin
        if (clr) count <= '0;
        else begin
            unique case (cmd)
                CMD_INC: count <= count + 1'b1;
                CMD_DEC: count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // R7: a count never exceeds the largest window
    a_r7_no_overflow: assert property (@(posedge clk) disable iff (clr)
        int'(count) <= MAX_CNT);
    // R6: a clear leaves the counter at zero
    a_r6_clear_zero: assert property (@(posedge clk)
        clr |=> count == '0);
    // R5: coincident increment and decrement leave the count unchanged
    a_r5_hold_stable: assert property (@(posedge clk) disable iff (clr)
        (inc && dec) |=> $stable(count));
endmodule

// File: rtl/cumhist_engine.sv
module cumhist_engine
    import cumhist_pkg::*;
#(
    parameter int SAMPLE_W = 12,
    parameter int BIN_BITS = 4,
    parameter int MIN_LOG  = 2,
    parameter int MAX_LOG  = 6,
    parameter int SEL_W    = 3,
    localparam int NBINS   = 1 << BIN_BITS,
    localparam int CNT_W   = MAX_LOG + 1,
    localparam int LOG_W   = $clog2(MAX_LOG + 1)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [SAMPLE_W-1:0]      smp_data,
    input  logic [SEL_W-1:0]         win_sel,
    output logic [NBINS*CNT_W-1:0]   bin_counts,
    output logic                     win_full,
    output logic [LOG_W-1:0]         frac_bits
);
    localparam int NUM_TAPS = MAX_LOG - MIN_LOG + 1;
    localparam int MAX_WIN  = 1 << MAX_LOG;

    logic [LOG_W-1:0]    sel_log;
    logic [LOG_W-1:0]    win_log_q;
    logic [CNT_W-1:0]    win_len;
    logic [CNT_W-1:0]    fill_q;
    logic                win_change;
    logic                clr_all;
    logic [BIN_BITS-1:0] add_idx;
    logic [BIN_BITS-1:0] drop_idx;
    logic [NBINS-1:0]    inc_mask;
    logic [NBINS-1:0]    dec_mask;
    logic [CNT_W-1:0]    counts [NBINS];

    // Window select decode, saturating at the longest tap
    always_comb begin
        if (int'(win_sel) >= NUM_TAPS) sel_log = LOG_W'(MAX_LOG);
        else                           sel_log = LOG_W'(MIN_LOG + int'(win_sel));
    end

    assign win_change = (sel_log != win_log_q);
    assign clr_all    = rst || win_change;
    assign win_len    = CNT_W'(1) << win_log_q;
    assign win_full   = (fill_q == win_len);
    assign frac_bits  = win_log_q;
    assign add_idx    = smp_data[SAMPLE_W-1 -: BIN_BITS];

    always_ff @(posedge clk) begin
        if (rst) begin
            win_log_q <= sel_log;
            fill_q    <= '0;
        end else if (win_change) begin
            win_log_q <= sel_log;
            fill_q    <= '0;
        end else if (!win_full) begin
            fill_q    <= fill_q + 1'b1;
        end
    end

    cumhist_delay #(
        .IDX_W(BIN_BITS), .MIN_LOG(MIN_LOG), .MAX_LOG(MAX_LOG), .LOG_W(LOG_W)
    ) u_delay (
        .clk(clk), .in_idx(add_idx), .win_log(win_log_q), .out_idx(drop_idx)
    );

    cumhist_pattern #(.IDX_W(BIN_BITS)) u_pattern (
        .add_idx(add_idx), .drop_idx(drop_idx), .drop_en(win_full),
        .inc_mask(inc_mask), .dec_mask(dec_mask)
    );

    for (genvar b = 0; b < NBINS; b++) begin : g_bin
        cumhist_bin #(.CNT_W(CNT_W), .MAX_CNT(MAX_WIN)) u_bin (
            .clk(clk), .clr(clr_all), .inc(inc_mask[b]), .dec(dec_mask[b]),
            .count(counts[b])
        );
        assign bin_counts[b*CNT_W +: CNT_W] = counts[b];
    end

    // R2: counts never fall with rising bin index
    for (genvar b = 1; b < NBINS; b++) begin : g_mono
        a_r2_monotonic: assert property (@(posedge clk) disable iff (rst)
            counts[b-1] <= counts[b]);
    end

    // R2: the highest bin counts every sample in the window
    a_r2_top_total: assert property (@(posedge clk) disable iff (rst)
        counts[NBINS-1] == fill_q);
    // R4: fill never passes the window length
    a_r4_fill_bound: assert property (@(posedge clk) disable iff (rst)
        fill_q <= win_len);
    // R6: a window change leaves the window empty
    a_r6_change_empty: assert property (@(posedge clk) disable iff (rst)
        win_change |=> (fill_q == '0 && counts[NBINS-1] == '0));
endmodule

// File: tb/cumhist_engine_bench.sv
module cumhist_engine_bench;
    localparam int NB  = 16;
    localparam int CW  = 7;
    localparam time CLK_P = 20ns;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic [11:0]    smp = '0;
    logic [2:0]     wsel = '0;
    logic [NB*CW-1:0] counts;
    logic           full;
    logic [2:0]     frac;

    int total = 0;
    int bad   = 0;
    int q[$];
    int m_log = 2;

    always #(CLK_P/2) clk = ~clk;

    cumhist_engine u_cumhist_engine (
        .clk(clk), .rst(rst), .smp_data(smp), .win_sel(wsel),
        .bin_counts(counts), .win_full(full), .frac_bits(frac)
    );

    function automatic int clamp_log(input int sel);
        return (sel >= 5) ? 6 : 2 + sel;
    endfunction

    function automatic int dut_cnt(input int b);
        return int'(counts[b*CW +: CW]);
    endfunction

    function automatic int exp_cnt(input int b);
        int n = 0;
        foreach (q[i]) if (q[i] <= b) n++;
        return n;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic model_edge(input logic [11:0] s, input logic [2:0] sel);
        int nl = clamp_log(int'(sel));
        if (rst) begin
            q.delete(); m_log = nl;
        end else if (nl != m_log) begin
            q.delete(); m_log = nl;
        end else begin
            q.push_back(int'(s[11:8]));
            if (q.size() > (1 << m_log)) void'(q.pop_front());
        end
    endtask

    task automatic compare_all();
        for (int b = 0; b < NB; b++) check(dut_cnt(b) == exp_cnt(b), "R2", dut_cnt(b), exp_cnt(b));
        check(full == (q.size() == (1 << m_log)), "R4", int'(full), int'(q.size() == (1 << m_log)));
        check(int'(frac) == m_log, "R8", int'(frac), m_log);
    endtask

    // Drive at the falling edge, let the rising edge act, compare at the next falling edge.
    task automatic step(input logic [11:0] s, input logic [2:0] sel);
        smp = s; wsel = sel;
        model_edge(s, sel);
        @(posedge clk);
        @(negedge clk);
        compare_all();
    endtask

    initial begin
        #(CLK_P * 200000);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        step(12'hFFF, 3'd0);
        step(12'h123, 3'd0);
        rst = 1'b0;
        // R9: reset state
        check(dut_cnt(15) == 0, "R9", dut_cnt(15), 0);
        check(full == 1'b0, "R9", int'(full), 0);

        // R1: index from the top bits only
        step(12'h5A3, 3'd0);
        check(dut_cnt(4) == 0, "R1", dut_cnt(4), 0);
        check(dut_cnt(5) == 1, "R1", dut_cnt(5), 1);
        step(12'h50F, 3'd0);
        check(dut_cnt(5) == 2, "R1", dut_cnt(5), 2);
        step(12'h4FF, 3'd0);
        check(dut_cnt(4) == 1, "R2", dut_cnt(4), 1);
        check(full == 1'b0, "R4", int'(full), 0);
        step(12'hC00, 3'd0);
        check(full == 1'b1, "R4", int'(full), 1);
        check(dut_cnt(15) == 4, "R4", dut_cnt(15), 4);

        // R3: oldest (index 5) leaves while index 0 enters
        step(12'h000, 3'd0);
        check(dut_cnt(0) == 1, "R3", dut_cnt(0), 1);
        check(dut_cnt(5) == 3, "R3", dut_cnt(5), 3);

        // R5: same index in and out
        for (int i = 0; i < 4; i++) step(12'h377, 3'd0);
        step(12'h3AA, 3'd0);
        check(dut_cnt(3) == 4, "R5", dut_cnt(3), 4);
        check(dut_cnt(2) == 0, "R5", dut_cnt(2), 0);

        // R6: window change clears, presented sample dropped
        step(12'h300, 3'd2);
        check(dut_cnt(15) == 0, "R6", dut_cnt(15), 0);
        check(full == 1'b0, "R6", int'(full), 0);
        check(int'(frac) == 4, "R8", int'(frac), 4);
        for (int i = 0; i < 20; i++) step(12'(i * 211), 3'd2);

        // R7: full 64-sample window of index 0
        step(12'h000, 3'd4);
        for (int i = 0; i < 80; i++) step(12'h0FF, 3'd4);
        check(dut_cnt(0) == 64, "R7", dut_cnt(0), 64);
        check(dut_cnt(15) == 64, "R7", dut_cnt(15), 64);
        // R3: select 7 saturates to the same length, no clear
        step(12'h012, 3'd7);
        check(dut_cnt(0) == 64, "R3", dut_cnt(0), 64);
        check(int'(frac) == 6, "R8", int'(frac), 6);

        // Mixed stream with occasional window changes
        for (int i = 0; i < 400; i++) begin
            logic [2:0] s;
            s = (i < 200) ? 3'd1 : ((i < 330) ? 3'd3 : 3'd0);
            step(12'($urandom), s);
        end

        // R9: reset mid-stream
        rst = 1'b1;
        step(12'hABC, 3'd1);
        rst = 1'b0;
        check(dut_cnt(15) == 0, "R9", dut_cnt(15), 0);
        for (int i = 0; i < 30; i++) step(12'($urandom), 3'd1);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule